// File: doc/BRIEF.md
# Auto-Train Retry Controller

This block sequences the control side of a serial link whose physical layer trains itself once it is told to. The controller does not look at the line. It drives enable and setting fields in a fixed order and waits fixed times between steps. After a training window it reads one flag that says whether the hardware training succeeded. If training fails and tries remain, it takes the link down step by step and tries again, moving to a stronger output buffer drive level every second attempt.

A single `start_i` pulse launches a run. The controller latches the number of buffer drive settings `num_levels_i` (N) and the lane count when the run starts. It then makes up to two attempts per setting. The run ends in one of two ways:
- On success, the pattern control switches to normal pixel transport.
- After the last failed attempt, the controller raises `fail_o` and leaves every block enabled as it stood.

The wait times are parameters: calibration, training window and buffer-idle timeout. When the buffer-idle wait times out, a sticky error flag is raised and the sequence continues.

Top module: `autotrain_retry_ctl`

## Requirements
- R1: After reset every output is 0.
- R2: Before each buffer enable, both lane power-down fields hold the parked value 2 (2'b10) and the receiver clock select is 1, meaning the link clock rather than the raw clock.
- R3: A run makes at most 2·max(N,1) attempts, where N=0 counts as 1. Attempt k (counted from 0) drives buffer level k/2 (integer division). The buffer width field is the latched lane count minus 1.
- R4: Within an attempt, the steps occur in this order:
  - The pattern control is set to enabled, pattern 1 (`pat_normal_o`=0), auto-train on and enhanced framing on, all while the buffer and receiver are off.
  - The buffer is enabled.
  - The receiver is enabled with auto-train on and the transfer-unit size set to 64.
  - No earlier than CAL_CYC cycles after the receiver enable, both lane power-down fields are cleared to 0.
- R5: When `train_done_i` is 1 at the end of a TRAIN_CYC training window, `done_o` rises. In that cycle `pat_normal_o`, `pat_auto_o`, `pat_enh_o`, `pat_en_o`, the buffer and the receiver are all 1.
- R6: After a failed attempt that is not the last, the tear-down runs in this order:
  - The receiver is switched off while the buffer is still on.
  - The buffer is switched off while the pattern is still enabled.
  - The pattern is switched off and returned to pattern 1.
  - The controller waits for buffer idle.
  - Both power-down fields return to 2.
  - The next attempt starts.
- R7: When the final attempt fails, `fail_o` is 1 and `done_o` is 0. The buffer, the receiver and the pattern enable stay at 1, and the power-down fields stay at 0.
- R8: If buffer idle does not arrive within IDLE_TMO cycles, `idle_err_o` is set, the tear-down continues, and the flag stays set until reset.
- R9: During a run, `start_i` and changes to `num_levels_i` or `lane_count_i` have no effect on that run.
- R10: A `start_i` after a run has ended clears `done_o` and `fail_o` and begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launches a run when idle or finished |
| num_levels_i | input | LVL_W | Number of buffer drive settings N |
| lane_count_i | input | LANE_W | Lane count, 1 or more |
| train_done_i | input | 1 | Auto-training completed flag from the PHY |
| buf_idle_i | input | 1 | Output buffer reports idle |
| buf_en_o | output | 1 | Output buffer enable |
| buf_level_o | output | LVL_W | Buffer drive level select |
| buf_width_o | output | LANE_W | Lane count minus 1 |
| rx_en_o | output | 1 | Receiver enable |
| rx_auto_o | output | 1 | Receiver auto-train enable |
| rx_clk_link_o | output | 1 | Receiver clock select, 1 = link clock |
| tu_size_o | output | TU_W | Transfer-unit size |
| lane0_pd_o | output | 2 | Lane 0 power-down field |
| lane1_pd_o | output | 2 | Lane 1 power-down field |
| pat_en_o | output | 1 | Training pattern control enable |
| pat_normal_o | output | 1 | Pattern select, 0 = pattern 1, 1 = normal |
| pat_auto_o | output | 1 | Pattern auto-train enable |
| pat_enh_o | output | 1 | Enhanced framing enable |
| done_o | output | 1 | Run ended in success |
| fail_o | output | 1 | Run ended with every attempt failed |
| idle_err_o | output | 1 | Sticky buffer-idle timeout flag |

## Verification
The bench varies three inputs:
- the attempt on which the training flag comes up, including never;
- N, from 0 to 4;
- the buffer-idle delay, from immediate to past the timeout.

Success on the first attempt shows that no tear-down is issued. Success part way through shows the level stepping k/2 and shows that the tear-down order repeats between attempts. Runs in which the flag never comes up show that the attempt limit is 2·max(N,1) and that the last attempt leaves the link enabled. A missing idle shows that the timeout path still advances and that the flag stays set. A start pulse with a changed N in the middle of a run shows that the latched configuration rules that run.

// File: rtl/atr_pkg.sv
package atr_pkg;

    // Parked value for a lane power-down field between attempts.
    localparam logic [1:0] PD_PARK = 2'd2;

    typedef enum logic [3:0] {
        ST_IDLE, ST_PREP, ST_PAT, ST_BUF, ST_RX, ST_CAL, ST_PDCLR, ST_TRAIN,
        ST_CHECK, ST_RXOFF, ST_BUFOFF, ST_PATOFF, ST_IDLEWAIT, ST_PDSET, ST_HOLD
    } atr_state_e;

    // One control action per cycle, issued by the sequencer to the register bank.
    typedef enum logic [3:0] {
        ACT_NONE, ACT_PREP, ACT_PAT_TRAIN, ACT_BUF_ON, ACT_RX_ON, ACT_PD_CLEAR,
        ACT_PASS, ACT_FAIL, ACT_RX_OFF, ACT_BUF_OFF, ACT_PAT_OFF, ACT_PD_SET
    } atr_act_e;

    typedef struct packed {
        logic en;
        logic normal;
        logic auto_tr;
        logic enh;
    } pat_ctl_t;

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/atr_timer.sv
module atr_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0) && !load;

    // R4: a wait window only shrinks unless reloaded
    assert_timer_shrinks_R4: assert property (@(posedge clk) disable iff (rst)
        !load |=> (cnt <= $past(cnt)));
endmodule

// File: rtl/atr_seq.sv
module atr_seq
    import atr_pkg::*;
#(
    parameter int LVL_W     = 4,
    parameter int LANE_W    = 3,
    parameter int TMR_W     = 6,
    parameter int CAL_CYC   = 8,
    parameter int TRAIN_CYC = 10,
    parameter int IDLE_TMO  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [LVL_W-1:0]  num_levels_i,
    input  logic [LANE_W-1:0] lane_count_i,
    input  logic              train_done_i,
    input  logic              buf_idle_i,
    input  logic              tmr_expired,
    output atr_act_e          act_o,
    output logic [LVL_W-1:0]  level_o,
    output logic [LANE_W-1:0] width_o,
    output logic              tmr_load,
    output logic [TMR_W-1:0]  tmr_val,
    output logic              tmo_o
);
    localparam int ATT_W = LVL_W + 1;

    atr_state_e        state, nstate;
    logic [ATT_W-1:0]  attempt, last_att;
    logic [LANE_W-1:0] lanes_q;
    logic              can_start;

    assign can_start = (state == ST_IDLE) || (state == ST_HOLD);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            attempt  <= '0;
            last_att <= '0;
            lanes_q  <= '0;
        end else begin
            state <= nstate;
            if (can_start && start_i) begin
                attempt  <= '0;
                lanes_q  <= lane_count_i;
                last_att <= (num_levels_i == '0) ? ATT_W'(1)
                                                 : {num_levels_i, 1'b0} - 1'b1;
            end else if (state == ST_PDSET) begin
                attempt <= attempt + 1'b1;
            end
        end
    end

    assign level_o = attempt[ATT_W-1:1];
    assign width_o = lanes_q - 1'b1;

    always_comb begin
        nstate   = state;
        act_o    = ACT_NONE;
        tmr_load = 1'b0;
        tmr_val  = '0;
        tmo_o    = 1'b0;
        unique case (state)
            ST_IDLE, ST_HOLD: if (start_i) nstate = ST_PREP;
            ST_PREP:   begin act_o = ACT_PREP;      nstate = ST_PAT; end
            ST_PAT:    begin act_o = ACT_PAT_TRAIN; nstate = ST_BUF; end
            ST_BUF:    begin act_o = ACT_BUF_ON;    nstate = ST_RX;  end
            ST_RX: begin
                act_o    = ACT_RX_ON;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(CAL_CYC);
                nstate   = ST_CAL;
            end
            ST_CAL:    if (tmr_expired) nstate = ST_PDCLR;
            ST_PDCLR: begin
                act_o    = ACT_PD_CLEAR;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(TRAIN_CYC);
                nstate   = ST_TRAIN;
            end
            ST_TRAIN:  if (tmr_expired) nstate = ST_CHECK;
            ST_CHECK: begin
                if (train_done_i) begin
                    act_o = ACT_PASS; nstate = ST_HOLD;
                end else if (attempt == last_att) begin
                    act_o = ACT_FAIL; nstate = ST_HOLD;
                end else begin
                    nstate = ST_RXOFF;
                end
            end
            ST_RXOFF:  begin act_o = ACT_RX_OFF;  nstate = ST_BUFOFF; end
            ST_BUFOFF: begin act_o = ACT_BUF_OFF; nstate = ST_PATOFF; end
            ST_PATOFF: begin
                act_o    = ACT_PAT_OFF;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(IDLE_TMO);
                nstate   = ST_IDLEWAIT;
            end
            ST_IDLEWAIT: begin
                if (buf_idle_i) begin
                    nstate = ST_PDSET;
                end else if (tmr_expired) begin
                    tmo_o  = 1'b1;
                    nstate = ST_PDSET;
                end
            end
            ST_PDSET:  begin act_o = ACT_PD_SET; nstate = ST_PAT; end
            default:   nstate = ST_IDLE;
        endcase
    end

    // R3: the attempt index never passes the latched limit
    assert_attempt_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |-> (attempt <= last_att));
    // R9: a start pulse inside a run does not restart it
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (!can_start && start_i) |=> (state != ST_PREP));
endmodule

// File: rtl/atr_ctl.sv
module atr_ctl
    import atr_pkg::*;
#(
    parameter int LVL_W   = 4,
    parameter int LANE_W  = 3,
    parameter int TU_W    = 7,
    parameter int TU_SIZE = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  atr_act_e          act_i,
    input  logic [LVL_W-1:0]  level_i,
    input  logic [LANE_W-1:0] width_i,
    input  logic              tmo_i,
    output logic              buf_en,
    output logic [LVL_W-1:0]  buf_level,
    output logic [LANE_W-1:0] buf_width,
    output logic              rx_en,
    output logic              rx_auto,
    output logic              rx_clk_link,
    output logic [TU_W-1:0]   tu_size,
    output logic [1:0]        pd0,
    output logic [1:0]        pd1,
    output pat_ctl_t          pat,
    output logic              done,
    output logic              fail,
    output logic              idle_err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            buf_en <= 1'b0; buf_level <= '0; buf_width <= '0;
            rx_en <= 1'b0; rx_auto <= 1'b0; rx_clk_link <= 1'b0;
            tu_size <= '0; pd0 <= '0; pd1 <= '0; pat <= '0;
            done <= 1'b0; fail <= 1'b0; idle_err <= 1'b0;
        end else begin
            if (tmo_i) idle_err <= 1'b1;
            unique case (act_i)
                ACT_PREP: begin
                    pd0 <= PD_PARK; pd1 <= PD_PARK; rx_clk_link <= 1'b1;
                    rx_en <= 1'b0; rx_auto <= 1'b0; buf_en <= 1'b0;
                    pat <= '0; done <= 1'b0; fail <= 1'b0;
                end
                ACT_PAT_TRAIN: pat <= '{en: 1'b1, normal: 1'b0, auto_tr: 1'b1, enh: 1'b1};
                ACT_BUF_ON: begin
                    buf_en <= 1'b1; buf_level <= level_i; buf_width <= width_i;
                end
                ACT_RX_ON: begin
                    tu_size <= TU_W'(TU_SIZE); rx_en <= 1'b1; rx_auto <= 1'b1;
                end
                ACT_PD_CLEAR: begin pd0 <= '0; pd1 <= '0; end
                ACT_PASS:     begin pat.normal <= 1'b1; done <= 1'b1; end
                ACT_FAIL:     fail <= 1'b1;
                ACT_RX_OFF:   rx_en <= 1'b0;
                ACT_BUF_OFF:  buf_en <= 1'b0;
                ACT_PAT_OFF:  begin pat.en <= 1'b0; pat.normal <= 1'b0; end
                ACT_PD_SET:   begin pd0 <= PD_PARK; pd1 <= PD_PARK; end
                default: ;
            endcase
        end
    end

    // R6: the receiver is never on without the buffer
    assert_rx_within_buf_R6: assert property (@(posedge clk) disable iff (rst)
        rx_en |-> buf_en);
    // R2: lanes parked and link clock chosen whenever the buffer comes up
    assert_parked_at_buf_on_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(buf_en) |-> (pd0 == PD_PARK && pd1 == PD_PARK && rx_clk_link));
    // R5: success lands in normal pattern with the link up
    assert_pass_state_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (pat.normal && pat.auto_tr && pat.enh && pat.en && buf_en && rx_en));
    // R7: the two outcomes exclude each other
    assert_outcome_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(done && fail));
    // R8: the timeout flag is sticky
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        idle_err |=> idle_err);
endmodule

// File: rtl/autotrain_retry_ctl.sv
module autotrain_retry_ctl
    import atr_pkg::*;
#(
    parameter int LVL_W     = 4,
    parameter int LANE_W    = 3,
    parameter int TU_W      = 7,
    parameter int TU_SIZE   = 64,
    parameter int CAL_CYC   = 8,
    parameter int TRAIN_CYC = 10,
    parameter int IDLE_TMO  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [LVL_W-1:0]  num_levels_i,
    input  logic [LANE_W-1:0] lane_count_i,
    input  logic              train_done_i,
    input  logic              buf_idle_i,
    output logic              buf_en_o,
    output logic [LVL_W-1:0]  buf_level_o,
    output logic [LANE_W-1:0] buf_width_o,
    output logic              rx_en_o,
    output logic              rx_auto_o,
    output logic              rx_clk_link_o,
    output logic [TU_W-1:0]   tu_size_o,
    output logic [1:0]        lane0_pd_o,
    output logic [1:0]        lane1_pd_o,
    output logic              pat_en_o,
    output logic              pat_normal_o,
    output logic              pat_auto_o,
    output logic              pat_enh_o,
    output logic              done_o,
    output logic              fail_o,
    output logic              idle_err_o
);
    localparam int TMR_MAX = int'(max3(CAL_CYC, TRAIN_CYC, IDLE_TMO));
    localparam int TMR_W   = $clog2(TMR_MAX + 1);

    atr_act_e          act;
    logic [LVL_W-1:0]  level;
    logic [LANE_W-1:0] width;
    logic              tmr_load, tmr_expired, tmo;
    logic [TMR_W-1:0]  tmr_val;
    pat_ctl_t          pat;

    atr_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired)
    );

    atr_seq #(
        .LVL_W(LVL_W), .LANE_W(LANE_W), .TMR_W(TMR_W),
        .CAL_CYC(CAL_CYC), .TRAIN_CYC(TRAIN_CYC), .IDLE_TMO(IDLE_TMO)
    ) u_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .num_levels_i(num_levels_i),
        .lane_count_i(lane_count_i), .train_done_i(train_done_i), .buf_idle_i(buf_idle_i),
        .tmr_expired(tmr_expired), .act_o(act), .level_o(level), .width_o(width),
        .tmr_load(tmr_load), .tmr_val(tmr_val), .tmo_o(tmo)
    );

    atr_ctl #(.LVL_W(LVL_W), .LANE_W(LANE_W), .TU_W(TU_W), .TU_SIZE(TU_SIZE)) u_ctl (
        .clk(clk), .rst(rst), .act_i(act), .level_i(level), .width_i(width), .tmo_i(tmo),
        .buf_en(buf_en_o), .buf_level(buf_level_o), .buf_width(buf_width_o),
        .rx_en(rx_en_o), .rx_auto(rx_auto_o), .rx_clk_link(rx_clk_link_o),
        .tu_size(tu_size_o), .pd0(lane0_pd_o), .pd1(lane1_pd_o), .pat(pat),
        .done(done_o), .fail(fail_o), .idle_err(idle_err_o)
    );

    assign pat_en_o     = pat.en;
    assign pat_normal_o = pat.normal;
    assign pat_auto_o   = pat.auto_tr;
    assign pat_enh_o    = pat.enh;
endmodule

// File: tb/tb_autotrain_retry_ctl.sv
`timescale 1ns/1ps
module tb_autotrain_retry_ctl;
    localparam int LVL_W = 4, LANE_W = 3, TU_W = 7;
    localparam int CAL = 8, TRN = 10, TMO = 32;

    logic clk = 1'b0, rst = 1'b1;
    logic start_i = 1'b0, train_done_i = 1'b0, buf_idle_i = 1'b0;
    logic [LVL_W-1:0] num_levels_i = '0;
    logic [LANE_W-1:0] lane_count_i = '0;
    logic buf_en_o, rx_en_o, rx_auto_o, rx_clk_link_o;
    logic [LVL_W-1:0] buf_level_o;
    logic [LANE_W-1:0] buf_width_o;
    logic [TU_W-1:0] tu_size_o;
    logic [1:0] lane0_pd_o, lane1_pd_o;
    logic pat_en_o, pat_normal_o, pat_auto_o, pat_enh_o, done_o, fail_o, idle_err_o;

    always #2.5 clk = ~clk;

    autotrain_retry_ctl #(.LVL_W(LVL_W), .LANE_W(LANE_W), .TU_W(TU_W), .TU_SIZE(64),
        .CAL_CYC(CAL), .TRAIN_CYC(TRN), .IDLE_TMO(TMO)) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .num_levels_i(num_levels_i),
        .lane_count_i(lane_count_i), .train_done_i(train_done_i), .buf_idle_i(buf_idle_i),
        .buf_en_o(buf_en_o), .buf_level_o(buf_level_o), .buf_width_o(buf_width_o),
        .rx_en_o(rx_en_o), .rx_auto_o(rx_auto_o), .rx_clk_link_o(rx_clk_link_o),
        .tu_size_o(tu_size_o), .lane0_pd_o(lane0_pd_o), .lane1_pd_o(lane1_pd_o),
        .pat_en_o(pat_en_o), .pat_normal_o(pat_normal_o), .pat_auto_o(pat_auto_o),
        .pat_enh_o(pat_enh_o), .done_o(done_o), .fail_o(fail_o), .idle_err_o(idle_err_o)
    );

    int checks = 0, fails = 0;
    int att = 0, exp_succ = -1, cur_lanes = 1, idle_delay = 0;
    int cyc = 0, rx_t = 0, low_cnt = 0;
    bit mon_on = 1'b0;
    logic p_buf = 1'b0, p_rx = 1'b0, p_pat = 1'b0;
    logic [1:0] p_pd = 2'd0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_attempts(input int n, input int succ);
        int ne;
        ne = (n == 0) ? 1 : n;
        return (succ < 0) ? 2 * ne : succ + 1;
    endfunction

    // Monitor and PHY model: samples at the falling edge, drives done and idle.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (mon_on) begin
                if (buf_en_o && !p_buf) begin
                    att++;
                    chk("R3 buffer level", int'(buf_level_o), (att - 1) / 2);
                    chk("R3 width field", int'(buf_width_o), cur_lanes - 1);
                    chk("R2 parked lanes and link clock",
                        int'(lane0_pd_o == 2'd2 && lane1_pd_o == 2'd2 && rx_clk_link_o), 1);
                    chk("R4 pattern 1 training before buffer",
                        int'(pat_en_o && !pat_normal_o && pat_auto_o && pat_enh_o && !rx_en_o), 1);
                    train_done_i = ((att - 1) == exp_succ);
                end
                if (rx_en_o && !p_rx) begin
                    chk("R4 receiver enable after buffer, tu 64, auto",
                        int'(buf_en_o && tu_size_o == 7'd64 && rx_auto_o), 1);
                    rx_t = cyc;
                end
                if (lane0_pd_o == 2'd0 && p_pd == 2'd2 && rx_en_o)
                    chk("R4 calibration wait before power-up", int'((cyc - rx_t) >= CAL), 1);
                if (!rx_en_o && p_rx)
                    chk("R6 receiver off with buffer still on", int'(buf_en_o && !done_o && !fail_o), 1);
                if (!buf_en_o && p_buf)
                    chk("R6 buffer off after receiver, pattern on", int'(!rx_en_o && pat_en_o), 1);
                if (!pat_en_o && p_pat)
                    chk("R6 pattern off to pattern 1 after buffer",
                        int'(!buf_en_o && !pat_normal_o && lane0_pd_o == 2'd0), 1);
                if (lane0_pd_o == 2'd2 && p_pd == 2'd0)
                    chk("R6 re-park after tear-down",
                        int'(!buf_en_o && !pat_en_o && lane1_pd_o == 2'd2), 1);
            end
            p_buf = buf_en_o; p_rx = rx_en_o; p_pat = pat_en_o; p_pd = lane0_pd_o;
            low_cnt = buf_en_o ? 0 : low_cnt + 1;
            buf_idle_i = !buf_en_o && (low_cnt > idle_delay);
        end
    end

    task automatic run(input int n, input int lanes, input int succ, input int idly, input bit poke);
        bit poked = 1'b0;
        int guard = 0;
        num_levels_i = LVL_W'(n); lane_count_i = LANE_W'(lanes);
        cur_lanes = lanes; exp_succ = succ; idle_delay = idly;
        att = 0; train_done_i = 1'b0;
        start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R10 outcome flags cleared by start", int'(done_o || fail_o), 0);
        mon_on = 1'b1;
        while (!(done_o || fail_o) && guard < 20000) begin
            @(negedge clk);
            guard++;
            if (poke && att == 2 && !poked) begin
                start_i = 1'b1; num_levels_i = 4'd1; lane_count_i = 3'd1; poked = 1'b1;
            end else begin
                start_i = 1'b0;
            end
        end
        mon_on = 1'b0;
        chk(poke ? "R9 attempts unchanged by mid-run start" : "R3 attempt count",
            att, exp_attempts(n, succ));
        if (succ >= 0) begin
            chk("R5 done", int'(done_o && !fail_o), 1);
            chk("R5 normal pattern, link up",
                int'(pat_normal_o && pat_en_o && pat_auto_o && pat_enh_o && buf_en_o && rx_en_o), 1);
        end else begin
            chk("R7 fail", int'(fail_o && !done_o), 1);
            chk("R7 blocks left enabled",
                int'(buf_en_o && rx_en_o && pat_en_o && lane0_pd_o == 2'd0 && lane1_pd_o == 2'd0), 1);
        end
        repeat (3) @(negedge clk);
        chk(succ >= 0 ? "R10 done holds until next start" : "R10 fail holds until next start",
            int'(succ >= 0 ? done_o : fail_o), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd17));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset outputs", int'({buf_en_o, buf_level_o, buf_width_o, rx_en_o, rx_auto_o,
            rx_clk_link_o, tu_size_o, lane0_pd_o, lane1_pd_o, pat_en_o, pat_normal_o,
            pat_auto_o, pat_enh_o, done_o, fail_o, idle_err_o} != '0), 0);

        run(1, 4, 0, 0, 1'b0);    // first-try success
        run(3, 2, -1, 2, 1'b0);   // all six attempts fail
        run(0, 1, -1, 0, 1'b0);   // N=0 behaves as one setting
        run(2, 3, -1, 1, 1'b1);   // R9 mid-run start with new N
        for (int k = 0; k < 8; k++) begin
            int n, ln, sc;
            n  = int'($urandom_range(4, 1));
            ln = int'($urandom_range(4, 1));
            sc = int'($urandom_range(2 * n, 0)) - 1;
            run(n, ln, sc, int'($urandom_range(5, 0)), 1'b0);
        end
        chk("R8 no timeout flag without a timeout", int'(idle_err_o), 0);
        run(1, 2, 1, 1000, 1'b0); // idle never comes: timeout path
        chk("R8 timeout flag set", int'(idle_err_o), 1);
        run(2, 2, 2, 0, 1'b0);
        chk("R8 timeout flag sticky", int'(idle_err_o), 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule